// File: doc/BRIEF.md
# Three-Lane 7:1 Word Serializer with Forwarded Frame Clock

This block turns a parallel word of up to 21 bits into three serial lanes. The word is cut into three 7-bit groups, and each group is shifted out on its own lane, one bit per fast-clock cycle. A fourth lane carries a forwarded clock with a fixed 7-bit shape, so a receiver can find the word boundaries. Everything runs in the fast clock domain. A single-cycle load strobe, normally pulsed once every seven fast cycles, captures each new word.

A mode input picks how many lanes carry data. In reduced mode only the two low groups (14 bits) are sent and the third lane stays low. In full mode all three groups are sent. If the strobe comes before a word has finished, the block drops the rest of that word and starts the new one at once. If no strobe comes after the seventh bit, every lane, including the clock lane, goes low and stays low.

Top module: `ser7_tx`

## Requirements
- R1: While reset is active, and after reset until the first load strobe, all three data lanes and the clock lane are low.
- R2: A high `load_i` at a rising clock edge captures `word_i` and `full_mode_i`. In the next cycle lane k (k = 0,1,2) outputs bit `word_i[7k]`.
- R3: Each group is sent least significant bit first. Bit b of group k, `word_i[7k+b]`, appears on lane k exactly b cycles after bit 0.
- R4: For the seven cycles after a load, the clock lane outputs 1,1,0,0,0,1,1. Its rising edge therefore comes either with bit 0 of a word that follows idle, or with bit 5.
- R5: With `full_mode_i`=1 at the load, lane 2 carries `word_i[20:14]`.
- R6: With `full_mode_i`=0 at the load, lane 2 stays low for the whole word and `word_i[20:14]` is ignored. Lanes 0 and 1 still carry `word_i[13:0]`.
- R7: A strobe on the cycle after bit 6 has been sent gives a stream with no gaps. The next word's bit 0 follows the previous word's bit 6 directly.
- R8: If no strobe arrives on the cycle after bit 6, all four lanes go low the next cycle and stay low until a strobe arrives.
- R9: A strobe in the middle of a word drops that word's remaining bits. The next cycle shows bit 0 of the new word, and the clock-lane pattern starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bit-rate) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Word load strobe, one cycle wide |
| full_mode_i | input | 1 | 1: three data lanes; 0: two data lanes (captured with the load) |
| word_i | input | 21 | Parallel word; bits [7k+6:7k] feed lane k |
| lane_o | output | 3 | Serial data lanes, bit k is lane k |
| fclk_o | output | 1 | Forwarded frame clock lane |

## Verification
On every cycle the assertions check four things: lanes stay quiet before the first load and after an unrenewed word; the first bit on each lane and the first clock-lane bit right after a strobe; that lane 2 follows the mode; and that clock-lane rising edges come only at frame position 0 or 5. Some behaviour is only visible from the bench's scenarios: the full seven-bit order on every lane, gapless streaming of back-to-back words, the clock-lane shape over a whole frame, and a mid-word restart. The bench compares every serial bit against values it builds from the input word.

// File: rtl/ser7_pkg.sv
package ser7_pkg;

    typedef enum logic {
        MODE_REDUCED = 1'b0,
        MODE_FULL    = 1'b1
    } lane_mode_e;

    // Frame clock shape for one word period: high for the first and last
    // (w-3)/2 bit slots, low in the middle.
    function automatic logic fwd_clk_bit(input int idx, input int w);
        int hi;
        hi = (w - 3) / 2;
        return (idx < hi) || (idx >= w - hi);
    endfunction

endpackage

// File: rtl/ser7_lane.sv
module ser7_lane #(
    parameter int GROUP_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               enable_i,
    input  logic [GROUP_W-1:0] group_i,
    output logic               bit_o
);

    typedef struct packed {
        logic [GROUP_W-1:0] shreg;
    } lane_state_t;

    lane_state_t st_d, st_q;

    // Zeros shift in from the top, so a word that is not renewed drains
    // to an all-low lane by itself.
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.shreg = enable_i ? group_i : '0;
        end else begin
            st_d.shreg = {1'b0, st_q.shreg[GROUP_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_o = st_q.shreg[0];

endmodule

// File: rtl/ser7_frame.sv
module ser7_frame #(
    parameter int GROUP_W = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic fclk_o
);
    import ser7_pkg::*;

    localparam int CNT_W = (GROUP_W > 1) ? $clog2(GROUP_W) : 1;
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(GROUP_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0] slot;
        logic             active;
    } frame_state_t;

    frame_state_t st_d, st_q;
    logic [GROUP_W-1:0] shape;

    genvar gi;
    generate
        for (gi = 0; gi < GROUP_W; gi++) begin : g_shape
            assign shape[gi] = fwd_clk_bit(gi, GROUP_W);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.slot   = '0;
            st_d.active = 1'b1;
        end else if (st_q.active) begin
            if (st_q.slot == LAST_SLOT) begin
                st_d.slot   = '0;
                st_d.active = 1'b0;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fclk_o = st_q.active && shape[st_q.slot];

endmodule

// File: rtl/ser7_tx.sv
module ser7_tx #(
    parameter int GROUP_W       = 7,
    parameter int NUM_LANES     = 3,
    parameter int REDUCED_LANES = 2,
    parameter int WORD_W        = GROUP_W * NUM_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 full_mode_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic [NUM_LANES-1:0] lane_o,
    output logic                 fclk_o
);
    import ser7_pkg::*;

    lane_mode_e mode;
    assign mode = lane_mode_e'(full_mode_i);

    genvar li;
    generate
        for (li = 0; li < NUM_LANES; li++) begin : g_lane
            logic lane_en;
            if (li < REDUCED_LANES) begin : g_always
                assign lane_en = 1'b1;
            end else begin : g_full_only
                assign lane_en = (mode == MODE_FULL);
            end

            ser7_lane #(.GROUP_W(GROUP_W)) lane_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .load_i   (load_i),
                .enable_i (lane_en),
                .group_i  (word_i[li*GROUP_W +: GROUP_W]),
                .bit_o    (lane_o[li])
            );
        end
    endgenerate

    ser7_frame #(.GROUP_W(GROUP_W)) frame_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .fclk_o (fclk_o)
    );

endmodule

// File: rtl/ser7_tx_chk.sv
module ser7_tx_chk #(
    parameter int GROUP_W   = 7,
    parameter int NUM_LANES = 3,
    parameter int WORD_W    = GROUP_W * NUM_LANES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_i,
    input logic                 full_mode_i,
    input logic [WORD_W-1:0]    word_i,
    input logic [NUM_LANES-1:0] lane_o,
    input logic                 fclk_o
);
    localparam int POS_W = $clog2(GROUP_W + 1);
    localparam logic [POS_W-1:0] POS_IDLE = POS_W'(GROUP_W);

    // Frame position counted independently: 0 on the bit-0 cycle,
    // saturating at GROUP_W once the word has drained.
    logic [POS_W-1:0] pos_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= POS_IDLE;
        end else if (load_i) begin
            pos_q <= '0;
        end else if (pos_q != POS_IDLE) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // R1 and R8: no word in flight means all lanes quiet
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == POS_IDLE) |-> (lane_o == '0 && !fclk_o));

    a_r2_first_bits: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (lane_o[0] == $past(word_i[0]) &&
                    lane_o[1] == $past(word_i[GROUP_W])));

    a_r4_clk_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> fclk_o);

    a_r4_rise_position: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fclk_o) |-> (pos_q == 0 || pos_q == POS_W'(5)));

    a_r5_full_lane2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && full_mode_i) |=> lane_o[2] == $past(word_i[2*GROUP_W]));

    a_r6_reduced_lane2_low: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !full_mode_i) |=> !lane_o[2]);

endmodule

bind ser7_tx ser7_tx_chk #(.GROUP_W(GROUP_W), .NUM_LANES(NUM_LANES), .WORD_W(WORD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .full_mode_i (full_mode_i),
    .word_i      (word_i),
    .lane_o      (lane_o),
    .fclk_o      (fclk_o)
);

// File: tb/ser7_tx_tb_top.sv
module ser7_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        load_i;
    logic        full_mode_i;
    logic [20:0] word_i;
    logic [2:0]  lane_o;
    logic        fclk_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ser7_tx dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .full_mode_i (full_mode_i),
        .word_i      (word_i),
        .lane_o      (lane_o),
        .fclk_o      (fclk_o)
    );

    // {full_mode, word}
    localparam logic [21:0] VEC_TAB [0:7] = '{
        {1'b1, 21'h1FFFFF},
        {1'b0, 21'h1FFFFF},
        {1'b1, 21'h000000},
        {1'b1, 21'h0AAAAA},
        {1'b1, 21'h155555},
        {1'b0, 21'h012345},
        {1'b1, 21'h1C0F81},
        {1'b1, 21'h0F0F0F}
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {fclk,lanes} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] expect_bits(input logic [20:0] w, input logic full, input int b);
        logic [3:0] e;
        e[0] = w[b];
        e[1] = w[7 + b];
        e[2] = full ? w[14 + b] : 1'b0;
        e[3] = (b < 2) || (b >= 5);
        return e;
    endfunction

    // Called at a negedge: drives a load, then samples nbits bit slots.
    task automatic send(input logic [20:0] w, input logic full, input int nbits, input string req);
        word_i      = w;
        full_mode_i = full;
        load_i      = 1'b1;
        for (int b = 0; b < nbits; b++) begin
            @(negedge clk);
            if (b == 0) load_i = 1'b0;
            check(req, {fclk_o, lane_o}, expect_bits(w, full, b));
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load_i = 1'b0; full_mode_i = 1'b1; word_i = 21'h1FFFFF;
        repeat (3) @(negedge clk);
        check("R1 in reset", {fclk_o, lane_o}, 4'b0000);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 before first load", {fclk_o, lane_o}, 4'b0000);
        end

        // R2 R3 R4 R5 R6 R7: back-to-back stream of table words
        for (int v = 0; v < 8; v++) begin
            send(VEC_TAB[v][20:0], VEC_TAB[v][21], 7,
                 VEC_TAB[v][21] ? "R2/R3/R4/R5/R7 stream" : "R6 reduced mode");
        end

        // R8: no strobe after bit 6
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R8 idle after word", {fclk_o, lane_o}, 4'b0000);
        end

        // R9: mid-word strobe restarts the frame
        send(21'h1FFFFF, 1'b1, 3, "R9 first part");
        send(21'h0B3A5C, 1'b1, 7, "R9 restarted word");
        @(negedge clk);
        check("R8 idle after restart", {fclk_o, lane_o}, 4'b0000);

        // R6: reduced word after idle, upper group all ones
        send(21'h1FC000, 1'b0, 7, "R6 upper group ignored");

        // R1: reset mid-word
        send(21'h1FFFFF, 1'b1, 2, "R3 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-word", {fclk_o, lane_o}, 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after mid-word reset", {fclk_o, lane_o}, 4'b0000);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule